// File: doc/BRIEF.md
# Keyed Configuration Port

This block is a configuration register interface reached through two byte-wide ports: an index port and a data port. After reset it is locked. It ignores register traffic until a four-byte key arrives on the index port. The last byte of that key depends on which of two base addresses the host is using. Once the port is unlocked, the host writes a register number to the index port and then reads or writes that register through the data port.

A device-select register picks which bank of per-device registers appears at a set of shared indices. Each bank holds a 16-bit base address and a control byte. Read-only identity registers give a 16-bit chip identifier and a 4-bit revision. Writing the exit code to the control register locks the port again.

Reads are combinational from the current state. A read therefore sees the state as it stood before any write in the same cycle.

Top module: `cfg_key_port`

## Requirements
- R1: After reset the port is locked and the key matcher waits for its first byte. The index is 0x00 and the device select is 0. Every bank has base-high 0x0A, base-low equal to 16 times its device number, and control 0x00.
- R2: Index-port writes of 0x87, 0x01, 0x55 and then a fourth byte unlock the port. The fourth byte is 0x55 when alt_base is 0 and 0xAA when alt_base is 1. The unlocked output rises in the cycle after the fourth write.
- R3: A wrong byte at any point of the key restarts matching. If that wrong byte is 0x87, it counts as the first key byte.
- R4: While locked, reads of either port return 0xFF and data-port writes change no register. Index-port writes only feed the key matcher.
- R5: While unlocked, an index-port write stores the register number and an index-port read returns it. A write of 0xAA (or any other value) to the index port never relocks the port.
- R6: Index 0x20 reads the chip ID high byte, 0x21 reads the low byte, and 0x22 reads the revision in bits 3:0 with bits 7:4 zero. Writes to these indices are ignored.
- R7: Index 0x07 is the device-select register. It is read/write, holds all 8 bits, and keeps its value across lock and unlock.
- R8: Three indices are banked per device: 0x60 is base-high, 0x61 is base-low and 0xF0 is control. Each reads and writes the bank chosen by device select, and leaves the other banks unchanged.
- R9: With a device select of NUM_DEV or more, banked indices read 0xFF and writes to them are ignored.
- R10: Writing 0x02 to index 0x02 locks the port from the next cycle, clears the index and restarts key matching. Any other value written there has no effect. Index 0x02 and every unassigned index read 0x00.
- R11: rdata reflects the state before a write in the same cycle, so a read issued with the final key byte returns 0xFF, and a read issued with the relocking write returns the register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_base | input | 1 | 1 when the alternate base address is in use |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 index port, 1 data port |
| wdata | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 index port, 1 data port |
| rdata | output | 8 | Read data for the selected port |
| unlocked | output | 1 | Port is open for register access |

## Verification
A read and a write can land in the same cycle, and the two cases that matter most are the final key byte and the relocking write. The bench puts a data-port read on the same cycle as the fourth key byte and expects 0xFF. It puts a data-port read on the same cycle as the exit write to the control register and expects the register value 0x00, with the port locked in the following cycle. A behavioural model updates only after each edge, so it judges every such pairing, including those in a long pseudo-random stream of mixed key bytes and register accesses.

// File: rtl/cfg_key_port.sv
module cfg_key_port #(
  parameter int         NUM_DEV     = 4,
  parameter logic [15:0] CHIP_ID    = 16'h8A3C,
  parameter logic [3:0]  CHIP_REV   = 4'h5,
  parameter logic [7:0]  BASE_HI_RST = 8'h0A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alt_base,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wdata,
  input  logic       rd_sel,
  output logic [7:0] rdata,
  output logic       unlocked
);
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam logic [7:0] IX_CTRL = 8'h02, IX_LDN = 8'h07, IX_IDH = 8'h20,
                         IX_IDL = 8'h21, IX_REV = 8'h22, IX_BHI = 8'h60,
                         IX_BLO = 8'h61, IX_DCTL = 8'hF0;
  localparam logic [7:0] EXIT_CODE = 8'h02;

  logic [1:0] key_st;
  logic       open_q;
  logic [7:0] idx_q, ldn_q;
  logic [7:0] bhi [NUM_DEV];
  logic [7:0] blo [NUM_DEV];
  logic [7:0] dctl[NUM_DEV];

  wire [7:0] key_exp = (key_st == 2'd0) ? 8'h87 :
                       (key_st == 2'd1) ? 8'h01 :
                       (key_st == 2'd2) ? 8'h55 :
                       (alt_base ? 8'hAA : 8'h55);
  wire idx_wr   = wr_en & ~wr_sel;
  wire dat_wr   = wr_en & wr_sel & open_q;
  wire dev_ok   = ldn_q < 8'(NUM_DEV);
  wire [DEV_W-1:0] dev = ldn_q[DEV_W-1:0];
  wire relock   = dat_wr && idx_q == IX_CTRL && wdata == EXIT_CODE;

  assign unlocked = open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_st <= 2'd0;
      open_q <= 1'b0;
      idx_q  <= 8'h00;
    end else if (relock) begin
      key_st <= 2'd0;
      open_q <= 1'b0;
      idx_q  <= 8'h00;
    end else if (idx_wr) begin
      if (open_q) idx_q <= wdata;
      else if (wdata == key_exp) begin
        if (key_st == 2'd3) begin
          open_q <= 1'b1;
          key_st <= 2'd0;
        end else key_st <= key_st + 2'd1;
      end else key_st <= (wdata == 8'h87) ? 2'd1 : 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ldn_q <= 8'h00;
    else if (dat_wr && idx_q == IX_LDN) ldn_q <= wdata;
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
    wire sel = dat_wr && dev_ok && dev == DEV_W'(g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bhi[g]  <= BASE_HI_RST;
        blo[g]  <= 8'(g * 16);
        dctl[g] <= 8'h00;
      end else if (sel) begin
        if (idx_q == IX_BHI)  bhi[g]  <= wdata;
        if (idx_q == IX_BLO)  blo[g]  <= wdata;
        if (idx_q == IX_DCTL) dctl[g] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = 8'hFF;
    if (open_q) begin
      if (!rd_sel) rdata = idx_q;
      else begin
        case (idx_q)
          IX_LDN:  rdata = ldn_q;
          IX_IDH:  rdata = CHIP_ID[15:8];
          IX_IDL:  rdata = CHIP_ID[7:0];
          IX_REV:  rdata = {4'h0, CHIP_REV};
          IX_BHI:  rdata = dev_ok ? bhi[dev]  : 8'hFF;
          IX_BLO:  rdata = dev_ok ? blo[dev]  : 8'hFF;
          IX_DCTL: rdata = dev_ok ? dctl[dev] : 8'hFF;
          default: rdata = 8'h00;
        endcase
      end
    end
  end
endmodule

module cfg_key_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       alt_base,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wdata,
  input logic       rd_sel,
  input logic [7:0] rdata,
  input logic       unlocked,
  input logic [7:0] idx_q,
  input logic [7:0] ldn_q
);
  p_unlock_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(wr_en && !wr_sel && wdata == (alt_base ? 8'hAA : 8'h55)));

  p_locked_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> rdata == 8'hFF);

  p_locked_ldn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && wr_en && wr_sel) |=> $stable(ldn_q));

  p_stay_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && !(wr_en && wr_sel)) |=> unlocked);

  p_relock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && wr_en && wr_sel && idx_q == 8'h02 && wdata == 8'h02) |=> (!unlocked && idx_q == 8'h00));

  p_rev_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && rd_sel && idx_q == 8'h22) |-> rdata[7:4] == 4'h0);
endmodule

bind cfg_key_port cfg_key_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .alt_base(alt_base), .wr_en(wr_en),
  .wr_sel(wr_sel), .wdata(wdata), .rd_sel(rd_sel), .rdata(rdata),
  .unlocked(unlocked), .idx_q(idx_q), .ldn_q(ldn_q)
);

// File: tb/cfg_key_port_tb_top.sv
`timescale 1ns/1ps
module cfg_key_port_tb_top;
  localparam int ND = 4;
  logic clk = 1'b0, rst_n = 1'b0, alt_base = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic unlocked;

  cfg_key_port dut_i (.clk(clk), .rst_n(rst_n), .alt_base(alt_base), .wr_en(wr_en),
    .wr_sel(wr_sel), .wdata(wdata), .rd_sel(rd_sel), .rdata(rdata), .unlocked(unlocked));

  always #2.5 clk = ~clk;

  int vec = 0, bad = 0;
  int m_stage, m_open, m_idx, m_ldn;
  int m_hi[ND], m_lo[ND], m_ct[ND];

  task automatic m_reset();
    m_stage = 0; m_open = 0; m_idx = 0; m_ldn = 0;
    for (int d = 0; d < ND; d++) begin m_hi[d] = 'h0A; m_lo[d] = 16*d; m_ct[d] = 0; end
  endtask

  function automatic int m_read(int sel);
    if (!m_open) return 'hFF;
    if (!sel) return m_idx;
    case (m_idx)
      'h07: return m_ldn;
      'h20: return 'h8A;
      'h21: return 'h3C;
      'h22: return 'h05;
      'h60: return (m_ldn < ND) ? m_hi[m_ldn] : 'hFF;
      'h61: return (m_ldn < ND) ? m_lo[m_ldn] : 'hFF;
      'hF0: return (m_ldn < ND) ? m_ct[m_ldn] : 'hFF;
      default: return 0;
    endcase
  endfunction

  task automatic m_write(int sel, int d);
    int key[4];
    key = '{'h87, 'h01, 'h55, alt_base ? 'hAA : 'h55};
    if (!sel) begin
      if (m_open) m_idx = d;
      else if (d == key[m_stage]) begin
        if (m_stage == 3) begin m_open = 1; m_stage = 0; end
        else m_stage++;
      end else m_stage = (d == 'h87) ? 1 : 0;
    end else if (m_open) begin
      if (m_idx == 'h02 && d == 'h02) begin m_open = 0; m_stage = 0; m_idx = 0; end
      else if (m_idx == 'h07) m_ldn = d;
      else if (m_ldn < ND) begin
        if (m_idx == 'h60) m_hi[m_ldn] = d;
        if (m_idx == 'h61) m_lo[m_ldn] = d;
        if (m_idx == 'hF0) m_ct[m_ldn] = d;
      end
    end
  endtask

  task automatic cmp(string tag);
    int er;
    er = m_read(rd_sel);
    vec++;
    if (rdata !== 8'(er) || unlocked !== (m_open != 0)) begin
      bad++;
      $display("FAIL %s: rdata=%02h unlocked=%0b expected rdata=%02h unlocked=%0d",
               tag, rdata, unlocked, er, m_open);
    end
  endtask

  task automatic step(bit we, bit ws, int d, bit rs, string tag);
    @(negedge clk);
    wr_en = we; wr_sel = ws; wdata = 8'(d); rd_sel = rs;
    #1 cmp(tag);
    @(posedge clk);
    if (we) m_write(ws, d);
  endtask

  task automatic idx(int i, string tag);  step(1, 0, i, 0, tag); endtask
  task automatic dw(int d, string tag);   step(1, 1, d, 1, tag); endtask
  task automatic dr(string tag);          step(0, 0, 0, 1, tag); endtask
  task automatic key(string tag);
    idx('h87, tag); idx('h01, tag); idx('h55, tag); idx(alt_base ? 'hAA : 'h55, tag);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    int lf;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 cmp("R1 reset locked");
    dr("R4 locked data read");
    step(0, 0, 0, 0, "R4 locked index read");
    idx('h07, "R4"); dw('h03, "R4 locked write ignored");
    // R3: wrong byte restarts, 0x87 counts as first byte
    idx('h87, "R3"); idx('h01, "R3"); idx('h87, "R3"); idx('h01, "R3");
    idx('h55, "R3"); idx('h55, "R3 restart via 0x87");
    dr("R2 unlocked primary");
    idx('hAA, "R5 0xAA index while open"); step(0, 0, 0, 0, "R5 index readback");
    idx('h07, "R7"); dr("R7 select still 0 after locked write");
    idx('h20, "R6"); dr("R6 id hi"); dw('h11, "R6"); dr("R6 write ignored");
    idx('h21, "R6"); dr("R6 id lo"); idx('h22, "R6"); dr("R6 rev");
    for (int d = 0; d < ND; d++) begin
      idx('h07, "R7"); dw(d, "R7 select");
      idx('h60, "R8"); dr("R1 base hi reset"); dw('h30 + d, "R8");
      idx('h61, "R8"); dr("R1 base lo reset"); dw('hC0 + d, "R8");
      idx('hF0, "R8"); dr("R1 ctl reset"); dw('h5A ^ d, "R8");
    end
    for (int d = 0; d < ND; d++) begin
      idx('h07, "R8"); dw(d, "R8");
      idx('h60, "R8"); dr("R8 bank hi"); idx('h61, "R8"); dr("R8 bank lo");
      idx('hF0, "R8"); dr("R8 bank ctl");
    end
    idx('h07, "R9"); dw(ND + 3, "R9"); idx('h60, "R9"); dr("R9 out of range");
    dw('h77, "R9 write ignored"); idx('h07, "R9"); dw(1, "R9");
    idx('h60, "R9"); dr("R9 bank untouched");
    idx('h33, "R10"); dr("R10 unassigned index");
    idx('h02, "R10"); dr("R10 ctrl reads 0"); dw('h01, "R10 other value");
    step(1, 1, 'h02, 1, "R11 read with relock"); dr("R10 locked again");
    step(0, 0, 0, 0, "R10 index port locked");
    alt_base = 1'b1;
    idx('h87, "R2"); idx('h01, "R2"); idx('h55, "R2"); idx('h55, "R2 wrong 4th on alt");
    dr("R2 still locked");
    idx('h87, "R2"); idx('h01, "R2"); idx('h55, "R2");
    step(1, 0, 'hAA, 1, "R11 read with final key byte");
    dr("R2 unlocked alternate");
    idx('h07, "R7"); dr("R7 select kept across lock");
    lf = 'h1ACE;
    for (int n = 0; n < 3000; n++) begin
      lf = ((lf << 1) | (((lf >> 15) ^ (lf >> 13) ^ (lf >> 12) ^ (lf >> 10)) & 1)) & 'hFFFF;
      if (lf[3:0] == 0) alt_base = ~alt_base;
      case (lf[6:4])
        0, 1: key("R2 stream key");
        2: idx((lf[9]) ? 'h87 : lf[15:8], "R3 stream index");
        3: idx(lf[8] ? 'h07 : (lf[9] ? 'h60 : (lf[10] ? 'h61 : 'hF0)), "R8 stream index");
        4: dw(lf[8] ? (lf[15:9] & 7) : lf[15:8], "R8 stream write");
        5: step(1, 1, 'h02, lf[8], "R10 stream exit");
        default: step(0, 0, 0, lf[8], "R5 stream read");
      endcase
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule